// File: doc/BRIEF.md
# External Bus Strobe Generator

This block produces the two timing strobes of a multiplexed external memory bus: an active-high address-latch pulse and an active-low code-read strobe. It runs on the oscillator-rate clock and divides each machine cycle into twelve ticks, six states of two ticks each. The current tick is exported as a phase index so that the address/data multiplexing logic around it can align to the same cycle.

The CPU sequencer tells the block one machine cycle ahead whether the next cycle is an external data access, and whether it is a code-table read. In a data-access cycle the second address-latch pulse and both code-read pulses are withheld, so the bus is free for the data transfer. A single configuration bit can be written at a fixed register address. When set, it silences the address-latch output, which then rests high, except in data-access or code-read cycles. The bit is overridden while the device executes from external program memory.

Top module: `bus_strobe_gen`

## Requirements
- R1: `phase` is 0 while `rst` is high, then advances by one on every clock and wraps from 11 to 0, so one machine cycle spans 12 clocks.
- R2: In an ordinary cycle `ale` is high at phases 0, 1, 6 and 7 and low at all other phases. This gives two pulses per cycle, a rate of one sixth of the clock.
- R3: In a data-access cycle `ale` is high at phases 0 and 1 and low at phases 2 to 11, so the pulse at phases 6 and 7 is skipped.
- R4: With `ext_exec` high in a cycle that is not a data access, `psen_n` is low at phases 3, 4, 5, 9, 10 and 11 and high at the others. This gives two strobes per cycle.
- R5: In a data-access cycle `psen_n` stays high at every phase.
- R6: While `ext_exec` is low, `psen_n` stays high.
- R7: A clock edge with `cfg_we` high and `cfg_addr` equal to 8'h8E stores `cfg_wdata[0]` as the latch-disable bit, which takes effect from the next clock. Writes to any other address leave it unchanged. Reset clears the bit to 0.
- R8: With the disable bit set and `ext_exec` low, `ale` stays high at all 12 phases of a cycle that is neither a data access nor a code read.
- R9: With the disable bit set, `ale` follows R2 in a code-read cycle and follows R3 in a data-access cycle.
- R10: While `ext_exec` is high, the disable bit has no effect on `ale`.
- R11: `xdata_next` and `code_rd` are sampled only on the clock edge that ends phase 11, and they classify the whole following cycle. Their values at any other edge have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| xdata_next | input | 1 | The next machine cycle is an external data access |
| code_rd | input | 1 | The next machine cycle is a code-table read |
| ext_exec | input | 1 | Device executes from external program memory |
| cfg_we | input | 1 | Configuration register write enable |
| cfg_addr | input | 8 | Configuration register address |
| cfg_wdata | input | 8 | Configuration write data; bit 0 is the latch-disable bit |
| ale | output | 1 | Address latch enable, active high |
| psen_n | output | 1 | Code-read strobe, active low |
| phase | output | 4 | Tick index within the machine cycle, 0 to 11 |

## Verification
A wrong tick count shifts every strobe edge and shows on `phase` within one clock. A stale cycle classification shows during the next machine cycle: as a missing or extra latch pulse at phases 6 and 7, or as code-read strobes where the bus should be idle, at the latest 12 clocks after the sampling edge. A lost or spurious disable bit shows on `ale` at the very next off-pulse phase while external execution is off. Comparing the outputs against a tick-level model on every clock catches each of these at its first visible phase.

// File: rtl/bus_strobe_pkg.sv
`timescale 1ns/1ps
package bus_strobe_pkg;
    localparam int TICKS_PER_CYCLE = 12;
    localparam int HALF_CYCLE      = TICKS_PER_CYCLE / 2;
    localparam int ALE_TICKS       = 2;
    localparam int PSEN_FIRST      = 3;
    localparam int PH_W            = $clog2(TICKS_PER_CYCLE);

    typedef logic [PH_W-1:0] tick_t;

    typedef struct packed {
        logic data_acc;
        logic code_read;
    } cycle_kind_t;

    function automatic logic in_ale_slot(input tick_t t);
        return (int'(t) % HALF_CYCLE) < ALE_TICKS;
    endfunction

    function automatic logic in_psen_slot(input tick_t t);
        return (int'(t) % HALF_CYCLE) >= PSEN_FIRST;
    endfunction

    function automatic logic in_late_half(input tick_t t);
        return int'(t) >= HALF_CYCLE;
    endfunction
endpackage

// File: rtl/strobe_tick_ctr.sv
`timescale 1ns/1ps
module strobe_tick_ctr
    import bus_strobe_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    output tick_t tick,
    output logic  last
);
    localparam tick_t LAST_TICK = tick_t'(TICKS_PER_CYCLE - 1);

    always_ff @(posedge clk) begin
        if (rst)             tick <= '0;
        else if (last)       tick <= '0;
        else                 tick <= tick + tick_t'(1);
    end

    assign last = (tick == LAST_TICK);

    a_r1_wrap: assert property (@(posedge clk) disable iff (rst)
        (tick == LAST_TICK) |=> (tick == '0));
    a_r1_step: assert property (@(posedge clk) disable iff (rst)
        (tick != LAST_TICK) |=> (tick == $past(tick) + tick_t'(1)));
endmodule

// File: rtl/strobe_cycle_class.sv
`timescale 1ns/1ps
module strobe_cycle_class
    import bus_strobe_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        last,
    input  logic        xdata_next,
    input  logic        code_rd,
    output cycle_kind_t kind
);
    always_ff @(posedge clk) begin
        if (rst) begin
            kind <= '0;
        end else if (last) begin
            kind.data_acc  <= xdata_next;
            kind.code_read <= code_rd;
        end
    end

    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        !last |=> $stable(kind));
endmodule

// File: rtl/strobe_cfg_reg.sv
`timescale 1ns/1ps
module strobe_cfg_reg #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h8E
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              ale_off
);
    logic hit;
    logic unused_wdata_hi;

    assign hit = we && (addr == REG_ADDR);
    assign unused_wdata_hi = ^wdata[DATA_W-1:1];

    always_ff @(posedge clk) begin
        if (rst)      ale_off <= 1'b0;
        else if (hit) ale_off <= wdata[0];
    end

    a_r7_ignore: assert property (@(posedge clk) disable iff (rst)
        !hit |=> $stable(ale_off));
    a_r7_load: assert property (@(posedge clk) disable iff (rst)
        hit |=> (ale_off == $past(wdata[0])));
endmodule

// File: rtl/strobe_decode.sv
`timescale 1ns/1ps
module strobe_decode
    import bus_strobe_pkg::*;
(
    input  tick_t       tick,
    input  cycle_kind_t kind,
    input  logic        ale_off,
    input  logic        ext_exec,
    output logic        ale,
    output logic        psen_n
);
    logic ale_pulse;
    logic ale_live;

    always_comb begin
        ale_pulse = in_ale_slot(tick) && !(kind.data_acc && in_late_half(tick));
        ale_live  = !ale_off || ext_exec || kind.data_acc || kind.code_read;
        ale       = ale_live ? ale_pulse : 1'b1;
        psen_n    = !(ext_exec && !kind.data_acc && in_psen_slot(tick));
    end
endmodule

// File: rtl/bus_strobe_gen.sv
`timescale 1ns/1ps
module bus_strobe_gen
    import bus_strobe_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] CFG_ADDR = 8'h8E
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              xdata_next,
    input  logic              code_rd,
    input  logic              ext_exec,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic              ale,
    output logic              psen_n,
    output logic [PH_W-1:0]   phase
);
    tick_t       tick;
    logic        last;
    cycle_kind_t kind;
    logic        ale_off;

    strobe_tick_ctr u_ctr (
        .clk(clk), .rst(rst), .tick(tick), .last(last)
    );

    strobe_cycle_class u_cls (
        .clk(clk), .rst(rst), .last(last),
        .xdata_next(xdata_next), .code_rd(code_rd), .kind(kind)
    );

    strobe_cfg_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_ADDR(CFG_ADDR)) u_cfg (
        .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr),
        .wdata(cfg_wdata), .ale_off(ale_off)
    );

    strobe_decode u_dec (
        .tick(tick), .kind(kind), .ale_off(ale_off), .ext_exec(ext_exec),
        .ale(ale), .psen_n(psen_n)
    );

    assign phase = tick;

    a_r3_skip: assert property (@(posedge clk) disable iff (rst)
        (kind.data_acc && in_late_half(tick)) |-> !ale);
    a_r5_no_psen: assert property (@(posedge clk) disable iff (rst)
        kind.data_acc |-> psen_n);
    a_r6_psen_idle: assert property (@(posedge clk) disable iff (rst)
        !ext_exec |-> psen_n);
    a_r8_rest_high: assert property (@(posedge clk) disable iff (rst)
        (ale_off && !ext_exec && !kind.data_acc && !kind.code_read) |-> ale);
endmodule

// File: tb/sim_bus_strobe_gen.sv
`timescale 1ns/1ps
module sim_bus_strobe_gen;
    logic       clk = 0;
    logic       rst = 1;
    logic       xdata_next = 0, code_rd = 0, ext_exec = 0, cfg_we = 0;
    logic [7:0] cfg_addr = 0, cfg_wdata = 0;
    logic       ale, psen_n;
    logic [3:0] phase;

    int checks = 0, fails = 0;
    bit done = 0;

    // behavioural model state
    int m_tick = 0;
    bit m_xd = 0, m_cd = 0, m_dis = 0;

    always #2.5 clk = ~clk;

    bus_strobe_gen u0 (
        .clk(clk), .rst(rst), .xdata_next(xdata_next), .code_rd(code_rd),
        .ext_exec(ext_exec), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .ale(ale), .psen_n(psen_n), .phase(phase)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_tick = 0; m_xd = 0; m_cd = 0; m_dis = 0;
        end else begin
            if (m_tick == 11) begin m_xd = xdata_next; m_cd = code_rd; end
            m_tick = (m_tick + 1) % 12;
            if (cfg_we && cfg_addr == 8'h8E) m_dis = cfg_wdata[0];
        end
    end

    function automatic bit exp_ale();
        bit pulse, live;
        pulse = (m_tick % 6 < 2) && !(m_xd && m_tick >= 6);
        live  = !m_dis || ext_exec || m_xd || m_cd;
        return live ? pulse : 1'b1;
    endfunction

    function automatic bit exp_psen_n();
        return !(ext_exec && !m_xd && (m_tick % 6 >= 3));
    endfunction

    function automatic string ale_req();
        if (m_dis && ext_exec) return "R10";
        if (m_dis && (m_xd || m_cd)) return "R9";
        if (m_dis) return "R8";
        if (m_xd) return "R3";
        return "R2";
    endfunction

    function automatic string psen_req();
        if (!ext_exec) return "R6";
        if (m_xd) return "R5";
        return "R4";
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    // per-clock comparison against the model
    always @(posedge clk) begin
        #1;
        if (!done) begin
            check("R1", int'(phase), m_tick);
            check(ale_req(), int'(ale), int'(exp_ale()));
            check(psen_req(), int'(psen_n), int'(exp_psen_n()));
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_phase(input int p);
        @(negedge clk);
        while (int'(phase) != p) @(negedge clk);
    endtask

    task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
        cfg_we = 1; cfg_addr = a; cfg_wdata = d;
        step(1);
        cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
    endtask

    task automatic next_cycle_kind(input bit xd, input bit cd);
        wait_phase(11);
        xdata_next = xd; code_rd = cd;
        step(1);
        xdata_next = 0; code_rd = 0;
    endtask

    initial begin
        step(3);
        check("R1", int'(phase), 0);           // reset state
        check("R6", int'(psen_n), 1);
        rst = 0;
        step(24);                               // R2, R6 ordinary cycles
        ext_exec = 1;
        step(24);                               // R4 strobes
        next_cycle_kind(1, 0);                  // R3, R5 data cycle
        wait_phase(6);
        check("R3", int'(ale), 0);
        check("R5", int'(psen_n), 1);
        // R11: a mid-cycle request is not sampled
        wait_phase(4);
        xdata_next = 1; step(1); xdata_next = 0;
        wait_phase(6);
        check("R11", int'(ale), 1);
        wait_phase(9);
        check("R11", int'(psen_n), 0);
        ext_exec = 0;
        // R7: write to another address is ignored
        cfg_write(8'h8F, 8'h01);
        wait_phase(6);
        check("R7", int'(ale), 1);
        wait_phase(3);
        check("R7", int'(ale), 0);
        // R7/R8: disable bit set
        cfg_write(8'h8E, 8'hFF);
        wait_phase(3);
        check("R8", int'(ale), 1);
        step(14);
        // R9: code-read and data cycles still pulse
        next_cycle_kind(0, 1);
        wait_phase(3);
        check("R9", int'(ale), 0);
        wait_phase(6);
        check("R9", int'(ale), 1);
        next_cycle_kind(1, 0);
        wait_phase(1);
        check("R9", int'(ale), 1);
        wait_phase(7);
        check("R9", int'(ale), 0);
        // R10: external execution overrides
        ext_exec = 1;
        wait_phase(3);
        check("R10", int'(ale), 0);
        step(20);
        ext_exec = 0;
        cfg_write(8'h8E, 8'h00);                // R7 clear
        wait_phase(3);
        check("R7", int'(ale), 0);
        step(12);
        rst = 1;                                // R7 reset clears
        cfg_write(8'h8E, 8'h01);
        step(2);
        rst = 0;
        wait_phase(3);
        check("R7", int'(ale), 0);
        step(5);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule